// File: doc/BRIEF.md
# Packed Widening Unsigned Lane Multiplier

This block is a SIMD execution unit for a vector datapath of up to 512 bits, cut into eight 64-bit lanes. In every active lane it takes the low 32 bits of each source as an unsigned number and forms their 64-bit product. The product fills the whole lane. The upper 32 bits of each input lane play no part in the arithmetic.

Three operation forms are available:

- **Destructive form.** The first source is also the destination. Lanes outside the chosen vector length keep the first source's contents.
- **Non-destructive form.** A separate destination is written. Lanes outside the chosen vector length are cleared.
- **Masked form.** A per-lane write mask selects which lanes receive their product. Each unselected lane either keeps the old destination value or is cleared. This form can also replace the second source by one 64-bit value that is repeated into every lane.

The unit is a two-stage pipeline. It accepts one operation per clock, qualified by a valid strobe. The matching result leaves exactly two clocks later.

Top module: `packed_widen_mul`

## Requirements
- R1: In each active lane i (bits 64*i+63 down to 64*i), the result is the unsigned product of bits [31:0] of the source A lane and bits [31:0] of the source B lane. Bits [63:32] of either input lane never change the result.
- R2: The lane result is the full 64-bit product, with no truncation and no saturation. Two all-ones low halves give 64'hFFFFFFFE00000001, and a zero low half gives zero.
- R3: `vecLen` selects the number of active lanes, counted from lane 0: 0 gives one lane, 1 gives two, 2 gives four and 3 gives eight.
- R4: With `opForm` = 0 (destructive), every active lane receives its product. Every lane above the vector length returns the source A lane unchanged.
- R5: With `opForm` = 1 (non-destructive), every active lane receives its product and every lane above the vector length is zero. The value 3 behaves the same as 1. `oldDst` has no effect in either case.
- R6: With `opForm` = 2 (masked), `laneMask` bit i decides lane i. A set bit gives the product. A clear bit gives the `oldDst` lane when `zeroMask` = 0, and zero when `zeroMask` = 1. Lanes above the vector length are zero whatever their mask bit says.
- R7: With `opForm` = 2 and `bcastEn` = 1, bits [31:0] of `bcastVal` replace the source B low half in every lane. In forms 0, 1 and 3, `bcastEn` and `bcastVal` have no effect.
- R8: In forms 0, 1 and 3, `laneMask` and `zeroMask` have no effect; these forms act as if every mask bit were set.
- R9: An operation presented with `inValid` high on a clock edge produces `outValid` high, together with its result, after the second following edge. Back-to-back operations are accepted on every cycle. `outValid` is low two cycles after any cycle in which `inValid` is low.
- R10: While `rstN` is low, `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the valid pipeline |
| inValid | input | 1 | Operation present on the inputs this cycle |
| opForm | input | 2 | 0 destructive, 1 non-destructive, 2 masked, 3 same as 1 |
| vecLen | input | 2 | Active lane count: 0 one, 1 two, 2 four, 3 eight |
| laneMask | input | 8 | Per-lane write enable for the masked form, bit i for lane i |
| zeroMask | input | 1 | Masked form: 1 clears unselected lanes, 0 keeps oldDst |
| bcastEn | input | 1 | Masked form: use bcastVal as source B in every lane |
| srcA | input | 512 | First source; also the destination in the destructive form |
| srcB | input | 512 | Second source |
| oldDst | input | 512 | Previous destination contents, merged in the masked form |
| bcastVal | input | 64 | Scalar element repeated into every lane of source B |
| outValid | output | 1 | Result valid |
| result | output | 512 | Eight 64-bit lane results |

## Verification
The assertions assume that `inValid` is driven low whenever reset is active. They also assume that the operands stay stable in the cycle in which they are sampled, so that the value seen two edges later can be compared with the inputs that produced it. The bench drives every input once per cycle on the falling clock edge and holds `inValid` low until reset is released. Its random operations cover all four form codes and all vector lengths. The upper halves of the lanes are random, so the "ignored" claims are tested on every operation.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int NUM_LANES = 8;
  localparam int LANE_W    = 64;
  localparam int HALF_W    = LANE_W / 2;
  localparam int VEC_W     = NUM_LANES * LANE_W;
  localparam int LEN_W     = $clog2($clog2(NUM_LANES) + 1);

  typedef enum logic [1:0] {
    FORM_DESTR    = 2'd0,
    FORM_NONDESTR = 2'd1,
    FORM_MASKED   = 2'd2,
    FORM_ALT3     = 2'd3
  } opForm_e;

  // Strobes from control to datapath, valid in the input cycle.
  typedef struct packed {
    logic [NUM_LANES-1:0] wrLane;   // lane gets its product
    logic [NUM_LANES-1:0] keepLane; // lane not written keeps a prior value
    logic                 useOld;   // kept value comes from oldDst (else srcA)
    logic                 useBcast; // source B replaced by the scalar
    logic                 ld1;      // load stage 1
    logic                 ld2;      // load stage 2
  } ctrlStrobes_t;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int LANES = NUM_LANES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [1:0]         opForm,
  input  logic [LEN_W-1:0]   vecLen,
  input  logic [LANES-1:0]   laneMask,
  input  logic               zeroMask,
  input  logic               bcastEn,
  output ctrlStrobes_t       strobes,
  output logic               outValid
);

  localparam int CNT_W = $clog2(LANES) + 1;

  logic [LANES-1:0] lenMask;
  logic [CNT_W-1:0] activeCnt;
  logic             isMasked;
  logic             isDestr;
  logic             valid1;
  logic             valid2;

  assign activeCnt = CNT_W'(1) << vecLen;
  assign isMasked  = (opForm == FORM_MASKED);
  assign isDestr   = (opForm == FORM_DESTR);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_len
      assign lenMask[i] = (CNT_W'(i) < activeCnt);
    end
  endgenerate

  always_comb begin
    strobes = '0;
    strobes.ld1 = inValid;
    strobes.ld2 = valid1;
    if (isMasked) begin
      strobes.wrLane   = lenMask & laneMask;
      strobes.keepLane = zeroMask ? '0 : (lenMask & ~laneMask);
      strobes.useOld   = 1'b1;
      strobes.useBcast = bcastEn;
    end else if (isDestr) begin
      strobes.wrLane   = lenMask;
      strobes.keepLane = ~lenMask;
      strobes.useOld   = 1'b0;
      strobes.useBcast = 1'b0;
    end else begin
      strobes.wrLane   = lenMask;
      strobes.keepLane = '0;
      strobes.useOld   = 1'b0;
      strobes.useBcast = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid1 <= 1'b0;
      valid2 <= 1'b0;
    end else begin
      valid1 <= inValid;
      valid2 <= valid1;
    end
  end

  assign outValid = valid2;

endmodule

// File: rtl/pwm_dpath.sv
module pwm_dpath
  import pwm_pkg::*;
#(
  parameter int LANES = NUM_LANES,
  parameter int LW    = LANE_W
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  input  logic [LANES*LW-1:0] srcA,
  input  logic [LANES*LW-1:0] srcB,
  input  logic [LANES*LW-1:0] oldDst,
  input  logic [LW-1:0]     bcastVal,
  output logic [LANES*LW-1:0] result
);

  localparam int HW = LW / 2;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LW-1:0] laneA;
      logic [LW-1:0] laneB;
      logic [LW-1:0] laneOld;
      logic [LW-1:0] fillNext;
      logic [HW-1:0] opA1;
      logic [HW-1:0] opB1;
      logic          wr1;
      logic [LW-1:0] fill1;
      logic [LW-1:0] prod;
      logic [LW-1:0] res2;

      assign laneA   = srcA[i*LW +: LW];
      assign laneB   = strobes.useBcast ? bcastVal : srcB[i*LW +: LW];
      assign laneOld = oldDst[i*LW +: LW];

      always_comb begin
        if (!strobes.keepLane[i])  fillNext = '0;
        else if (strobes.useOld)   fillNext = laneOld;
        else                       fillNext = laneA;
      end

      // stage 1: operand halves and lane decision
      always_ff @(posedge clk) begin
        if (strobes.ld1) begin
          opA1  <= laneA[HW-1:0];
          opB1  <= laneB[HW-1:0];
          wr1   <= strobes.wrLane[i];
          fill1 <= fillNext;
        end
      end

      assign prod = {{HW{1'b0}}, opA1} * {{HW{1'b0}}, opB1};

      // stage 2: widened product or fill value
      always_ff @(posedge clk) begin
        if (strobes.ld2) begin
          res2 <= wr1 ? prod : fill1;
        end
      end

      assign result[i*LW +: LW] = res2;
    end
  endgenerate

endmodule

// File: rtl/packed_widen_mul.sv
module packed_widen_mul
  import pwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [1:0]           opForm,
  input  logic [LEN_W-1:0]     vecLen,
  input  logic [NUM_LANES-1:0] laneMask,
  input  logic                 zeroMask,
  input  logic                 bcastEn,
  input  logic [VEC_W-1:0]     srcA,
  input  logic [VEC_W-1:0]     srcB,
  input  logic [VEC_W-1:0]     oldDst,
  input  logic [LANE_W-1:0]    bcastVal,
  output logic                 outValid,
  output logic [VEC_W-1:0]     result
);

  ctrlStrobes_t strobes;

  pwm_ctrl #(.LANES(NUM_LANES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opForm   (opForm),
    .vecLen   (vecLen),
    .laneMask (laneMask),
    .zeroMask (zeroMask),
    .bcastEn  (bcastEn),
    .strobes  (strobes),
    .outValid (outValid)
  );

  pwm_dpath #(.LANES(NUM_LANES), .LW(LANE_W)) i_dpath (
    .clk      (clk),
    .strobes  (strobes),
    .srcA     (srcA),
    .srcB     (srcB),
    .oldDst   (oldDst),
    .bcastVal (bcastVal),
    .result   (result)
  );

endmodule

// File: rtl/pwm_chk.sv
module pwm_chk
  import pwm_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [1:0]           opForm,
  input logic [LEN_W-1:0]     vecLen,
  input logic [NUM_LANES-1:0] laneMask,
  input logic                 zeroMask,
  input logic [VEC_W-1:0]     srcA,
  input logic [VEC_W-1:0]     srcB,
  input logic                 outValid,
  input logic [VEC_W-1:0]     result
);

  localparam int TOP = VEC_W - LANE_W;

  // R9
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R9
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  // R10
  rst_valid_chk: assert property (@(posedge clk)
    !rstN |=> !outValid);

  // R1
  lane0_prod_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opForm != FORM_MASKED) |-> ##2
      (result[LANE_W-1:0] ==
       ({{HALF_W{1'b0}}, $past(srcA[HALF_W-1:0], 2)} *
        {{HALF_W{1'b0}}, $past(srcB[HALF_W-1:0], 2)})));

  // R4
  destr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opForm == FORM_DESTR && vecLen != '1) |-> ##2
      (result[VEC_W-1:TOP] == $past(srcA[VEC_W-1:TOP], 2)));

  // R5
  nondestr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opForm == FORM_NONDESTR && vecLen != '1) |-> ##2
      (result[VEC_W-1:TOP] == '0));

  // R6
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opForm == FORM_MASKED && !laneMask[0] && zeroMask) |-> ##2
      (result[LANE_W-1:0] == '0));

endmodule

bind packed_widen_mul pwm_chk i_pwm_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opForm   (opForm),
  .vecLen   (vecLen),
  .laneMask (laneMask),
  .zeroMask (zeroMask),
  .srcA     (srcA),
  .srcB     (srcB),
  .outValid (outValid),
  .result   (result)
);

// File: tb/test_packed_widen_mul.sv
`timescale 1ns/1ps
module test_packed_widen_mul;
  import pwm_pkg::*;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic [1:0]           opForm = '0;
  logic [LEN_W-1:0]     vecLen = '0;
  logic [NUM_LANES-1:0] laneMask = '0;
  logic                 zeroMask = 1'b0;
  logic                 bcastEn = 1'b0;
  logic [VEC_W-1:0]     srcA = '0;
  logic [VEC_W-1:0]     srcB = '0;
  logic [VEC_W-1:0]     oldDst = '0;
  logic [LANE_W-1:0]    bcastVal = '0;
  logic                 outValid;
  logic [VEC_W-1:0]     result;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic             expV1 = 1'b0, expV2 = 1'b0;
  logic [VEC_W-1:0] exp1 = '0, exp2 = '0;
  string            tag1 = "", tag2 = "";

  always #4 clk = ~clk;

  packed_widen_mul i_packed_widen_mul (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opForm(opForm),
    .vecLen(vecLen), .laneMask(laneMask), .zeroMask(zeroMask),
    .bcastEn(bcastEn), .srcA(srcA), .srcB(srcB), .oldDst(oldDst),
    .bcastVal(bcastVal), .outValid(outValid), .result(result)
  );

  function automatic logic [VEC_W-1:0] model(
    input logic [1:0] f, input logic [LEN_W-1:0] len,
    input logic [NUM_LANES-1:0] m, input logic zm, input logic be,
    input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
    input logic [VEC_W-1:0] od, input logic [LANE_W-1:0] bv);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      logic [63:0] aL, bL, oL, p, v;
      aL = a[i*64 +: 64];
      bL = (f == 2'd2 && be) ? bv : b[i*64 +: 64];
      oL = od[i*64 +: 64];
      p  = {32'd0, aL[31:0]} * {32'd0, bL[31:0]};
      if (i >= (1 << len))          v = (f == 2'd0) ? aL : 64'd0;
      else if (f != 2'd2 || m[i])   v = p;
      else                          v = zm ? 64'd0 : oL;
      r[i*64 +: 64] = v;
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] rndVec();
    logic [VEC_W-1:0] v;
    for (int k = 0; k < VEC_W / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // One cycle: check outputs, shift expectations, drive new operation.
  task automatic issue(input logic v, input logic [1:0] f,
                       input logic [LEN_W-1:0] len, input logic [7:0] m,
                       input logic zm, input logic be,
                       input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                       input logic [VEC_W-1:0] od, input logic [63:0] bv,
                       input string tag);
    @(negedge clk);
    testsRun++;
    if (outValid !== expV2) begin
      testsFailed++;
      $display("FAIL R9 outValid (%s): got %b expected %b", tag2, outValid, expV2);
    end
    if (expV2) begin
      testsRun++;
      if (result !== exp2) begin
        testsFailed++;
        $display("FAIL %s result: got %h expected %h", tag2, result, exp2);
      end
    end
    expV2 = expV1; exp2 = exp1; tag2 = tag1;
    inValid = v; opForm = f; vecLen = len; laneMask = m; zeroMask = zm;
    bcastEn = be; srcA = a; srcB = b; oldDst = od; bcastVal = bv;
    expV1 = v; tag1 = tag;
    exp1 = model(f, len, m, zm, be, a, b, od, bv);
  endtask

  task automatic idle();
    issue(1'b0, 2'd0, '0, '0, 1'b0, 1'b0, '0, '0, '0, '0, "R9");
  endtask

  initial begin
    logic [VEC_W-1:0] ones, hiOnly, a, b, od;
    void'($urandom(32'd20240611));
    ones   = '1;
    hiOnly = '0;
    for (int i = 0; i < NUM_LANES; i++) hiOnly[i*64 +: 64] = 64'hDEADBEEF_00000003;

    repeat (3) @(posedge clk);
    @(negedge clk);
    testsRun++;
    if (outValid !== 1'b0) begin
      testsFailed++;
      $display("FAIL R10 reset outValid: got %b expected 0", outValid);
    end
    rstN = 1'b1;

    // R2 all-ones and zero operands
    issue(1'b1, 2'd1, 2'd3, '0, 1'b0, 1'b0, ones, ones, '0, '0, "R2");
    issue(1'b1, 2'd1, 2'd3, '0, 1'b0, 1'b0, ones, '0, '0, '0, "R2");
    // R1 nonzero upper halves ignored
    issue(1'b1, 2'd1, 2'd3, '0, 1'b0, 1'b0, hiOnly, ones, '0, '0, "R1");
    issue(1'b1, 2'd0, 2'd3, '0, 1'b0, 1'b0, ones, hiOnly, '0, '0, "R1");
    // R3 each length; R4 destructive keeps srcA above length
    for (int l = 0; l < 4; l++)
      issue(1'b1, 2'd0, l[1:0], '0, 1'b0, 1'b0, rndVec(), rndVec(), '0, '0, "R4");
    // R5 non-destructive and code 3, oldDst ignored
    for (int l = 0; l < 4; l++)
      issue(1'b1, (l[0] ? 2'd3 : 2'd1), l[1:0], '0, 1'b0, 1'b0,
            rndVec(), rndVec(), ones, '0, "R5");
    // R6 merge and zeroing, mask bits above length
    issue(1'b1, 2'd2, 2'd3, 8'hA5, 1'b0, 1'b0, rndVec(), rndVec(), ones, '0, "R6");
    issue(1'b1, 2'd2, 2'd3, 8'hA5, 1'b1, 1'b0, rndVec(), rndVec(), ones, '0, "R6");
    issue(1'b1, 2'd2, 2'd1, 8'hFF, 1'b0, 1'b0, rndVec(), rndVec(), ones, '0, "R6");
    // R7 broadcast used in masked form, ignored in others
    issue(1'b1, 2'd2, 2'd3, 8'hFF, 1'b0, 1'b1, rndVec(), rndVec(), '0,
          64'hFFFFFFFF_00001234, "R7");
    issue(1'b1, 2'd1, 2'd3, 8'hFF, 1'b0, 1'b1, rndVec(), rndVec(), '0,
          64'h0000_0000_FFFF_FFFF, "R7");
    // R8 mask and zero control ignored outside the masked form
    issue(1'b1, 2'd1, 2'd3, 8'h00, 1'b1, 1'b0, rndVec(), rndVec(), ones, '0, "R8");
    issue(1'b1, 2'd0, 2'd2, 8'h00, 1'b1, 1'b0, rndVec(), rndVec(), ones, '0, "R8");
    // R9 gaps between operations
    idle();
    issue(1'b1, 2'd1, 2'd0, '0, 1'b0, 1'b0, rndVec(), rndVec(), '0, '0, "R9");
    idle();
    idle();

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] f;
      f = 2'($urandom_range(0, 3));
      a = rndVec(); b = rndVec(); od = rndVec();
      if ($urandom_range(0, 9) == 0) a[63:0] = 64'hFFFFFFFF_FFFFFFFF;
      if ($urandom_range(0, 9) == 0) b[31:0] = 32'd0;
      issue(($urandom_range(0, 7) != 0), f, 2'($urandom_range(0, 3)),
            8'($urandom), 1'($urandom), 1'($urandom), a, b, od,
            {$urandom, $urandom}, "R1");
    end
    idle();
    idle();
    idle();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R9 watchdog expired: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule